// File: doc/BRIEF.md
# Packet-Device Taskfile Controller

This block is the device end of a parallel-ATA packet interface. It keeps the taskfile registers the host sees: error/features, interrupt reason, LBA low, byte count low/high, device/head, status/command and alternate status/device control. It runs the packet handshake: a command is accepted, a fixed-length command packet is gathered byte by byte through the data port, and the packet goes to an execution backend. The backend's answer becomes either a data-ready report with a byte count or a completion whose error bits come from a sense key.

The host works through a single-access register port. One access is made per cycle: a write strobe or a read strobe with a 4-bit register address. Read data is combinational from the current register state, and side effects such as clearing the interrupt take place at the clock edge of the access. The backend takes a one-cycle packet strobe with the packet bytes and later answers with a done strobe, a transfer length and a 4-bit sense key. During the data phase each host read of the data port, or each DMA acknowledge when DMA was chosen, consumes one byte. The data contents and the DMA engine sit outside this block.

Top module: `pkt_taskfile_ctrl`

## Requirements
- R1: After power-on reset, once the device is selected, status reads 0x50. Error reads 0x01, interrupt reason 0x01, LBA low 0x01, byte count low 0x14 and byte count high 0xEB. The interrupt, packet strobe and DMA request outputs are low. Status bits are BSY=7, DRDY=6, DSC=4, DRQ=3 and ERR=0. Error bit 2 is ABRT.
- R2: The register addresses are: 0 data, 1 error/features, 2 interrupt reason, 3 LBA low, 4 byte count low, 5 byte count high, 6 device/head, 7 status/command, 8 alternate status/device control. Device/head bit 4 selects the device. When that bit differs from DRIVE_ID, every read returns 0, but writes to registers other than command still take effect.
- R3: A device/head write that selects this device while status is 0x00 sets status to 0x50. If status is nonzero, the write leaves status unchanged.
- R4: A selected read of address 7 clears the pending interrupt. A read of address 8 returns the same status and leaves the interrupt pending.
- R5: The interrupt output is high only when all four conditions hold: an interrupt is pending, device control bit 1 (mask) is clear, the device is selected, and no software reset is waiting.
- R6: Writing device control with bit 2 set while BSY is clear returns every register to its power-on value at once. This includes device/head, so the device becomes deselected when DRIVE_ID is 1.
- R7: Writing device control with bit 2 set while BSY is set holds BSY and suppresses the interrupt output. The full reset then runs on the cycle the backend reports done.
- R8: A command write is ignored while BSY or DRQ is set. While the device is deselected, every opcode except 0x90 is ignored.
- R9: Opcode 0xA0 clears the error register and sets status to 0x58 and interrupt reason to 1. After PKT_BYTES data-port writes, status becomes 0x90, both byte counts read 0 and interrupt reason reads 3. pkt_valid pulses for one cycle, the cycle after the last byte, with byte i on bits [8i+7:8i].
- R10: If the backend reports done with sense 0 and a nonzero length, the block loads the length low/high bytes into byte count low/high. It sets interrupt reason 2, status 0x58 and raises an interrupt. dma_req then follows features bit 0. Each data-port read, or each dma_ack in DMA mode, consumes one byte. The last byte completes with error 0x00, status 0x50, reason 3 and an interrupt.
- R11: If the backend reports done with a nonzero sense key k, or with length 0, the error register becomes k·16, with ABRT added for k=5 or k=11. Status becomes 0x50, or 0x51 when the error is nonzero. Interrupt reason becomes 3 and an interrupt is raised.
- R12: Opcodes 0xEC and 0x20 abort: status 0x51, error 0x04 and an interrupt. They also reload the signature: reason 1, LBA low 1, byte counts 0x14/0xEB, and device/head reduced to its select bit.
- R13: Any opcode that is not handled elsewhere aborts with status 0x51, error 0x04 and an interrupt. Interrupt reason, LBA low and the byte counts are left as they were.
- R14: Opcode 0x90 reloads the signature with device/head cleared, then sets error 0x01 and status 0x50 and raises an interrupt. Opcode 0x08 reloads the signature with the select bit kept and sets error 0x01 and status 0x00, with no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data (combinational) |
| intrq | output | 1 | Interrupt request to host |
| pkt_valid | output | 1 | One-cycle strobe: command packet ready |
| pkt_data | output | PKT_BYTES*8 | Collected command packet, byte 0 in the low bits |
| be_done | input | 1 | Backend finished the packet |
| be_len | input | LEN_W | Bytes the backend has for the host |
| be_sense | input | 4 | Sense key from the backend |
| dma_req | output | 1 | Data phase is waiting on DMA |
| dma_ack | input | 1 | DMA consumed one byte |

## Verification
The bench builds the block with DRIVE_ID at 1, so power-on leaves the device deselected. This brings the zero-read gating, the select-with-zero-status rule and the select bit cleared by 0x90 into reach from the first access. PKT_BYTES stays at 12 and LEN_W at 16. With these values the bench sweeps all 256 opcodes from a fresh reset and all 16 sense keys. It also drains data phases by PIO and by DMA at lengths whose high byte is zero and lengths whose high byte is nonzero.

// File: rtl/pkt_taskfile_pkg.sv
package pkt_taskfile_pkg;

    localparam logic [3:0] A_DATA = 4'd0;
    localparam logic [3:0] A_ERRF = 4'd1;
    localparam logic [3:0] A_RSN  = 4'd2;
    localparam logic [3:0] A_LBA  = 4'd3;
    localparam logic [3:0] A_BCL  = 4'd4;
    localparam logic [3:0] A_BCH  = 4'd5;
    localparam logic [3:0] A_DEV  = 4'd6;
    localparam logic [3:0] A_CMD  = 4'd7;
    localparam logic [3:0] A_CTL  = 4'd8;

    localparam int ST_BSY  = 7;
    localparam int ST_DRDY = 6;
    localparam int ST_DSC  = 4;
    localparam int ST_DRQ  = 3;
    localparam int ST_ERR  = 0;
    localparam int DEV_BIT = 4;
    localparam int CTL_MASK = 1;
    localparam int CTL_SRST = 2;

    localparam logic [7:0] ER_ABRT  = 8'h04;
    localparam logic [7:0] ER_BASE  = 8'h01;
    localparam logic [7:0] SIG_BC_LO = 8'h14;
    localparam logic [7:0] SIG_BC_HI = 8'hEB;

    localparam logic [7:0] RSN_PKT  = 8'h01;
    localparam logic [7:0] RSN_DATA = 8'h02;
    localparam logic [7:0] RSN_DONE = 8'h03;

    localparam logic [7:0] OP_DEV_RESET = 8'h08;
    localparam logic [7:0] OP_DIAG      = 8'h90;
    localparam logic [7:0] OP_PACKET    = 8'hA0;
    localparam logic [7:0] OP_IDENT     = 8'hEC;
    localparam logic [7:0] OP_READ      = 8'h20;

    localparam logic [3:0] SK_ILLEGAL = 4'h5;
    localparam logic [3:0] SK_ABORTED = 4'hB;

    typedef enum logic [1:0] {PH_IDLE, PH_PKT, PH_EXEC, PH_DATA} phase_e;

    typedef struct packed {
        logic [7:0] error;
        logic [7:0] features;
        logic [7:0] rsn;
        logic [7:0] lba_lo;
        logic [7:0] bc_lo;
        logic [7:0] bc_hi;
        logic [7:0] dev_head;
        logic [7:0] dev_ctl;
        logic [7:0] status;
        logic       int_pend;
        logic       rst_pend;
        phase_e     phase;
        logic       dma;
        logic       fire;
    } tf_state_t;

    localparam tf_state_t TF_POWER_ON = '{
        error: ER_BASE, features: 8'h00, rsn: RSN_PKT, lba_lo: 8'h01,
        bc_lo: SIG_BC_LO, bc_hi: SIG_BC_HI, dev_head: 8'h00, dev_ctl: 8'h00,
        status: 8'h00, int_pend: 1'b0, rst_pend: 1'b0, phase: PH_IDLE,
        dma: 1'b0, fire: 1'b0
    };

endpackage

// File: rtl/pkt_sense_map.sv
module pkt_sense_map
    import pkt_taskfile_pkg::*;
(
    input  logic [3:0] sense_key,
    output logic [7:0] err_byte
);
    logic abort_class;

    always_comb begin
        abort_class = (sense_key == SK_ILLEGAL) || (sense_key == SK_ABORTED);
        err_byte    = {sense_key, 4'h0} | (abort_class ? ER_ABRT : 8'h00);
    end
endmodule

// File: rtl/pkt_cmd_collector.sv
module pkt_cmd_collector #(
    parameter int PKT_BYTES = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   push,
    input  logic [7:0]             push_byte,
    output logic                   last,
    output logic [PKT_BYTES*8-1:0] bytes_flat
);
    localparam int IDX_W = (PKT_BYTES > 1) ? $clog2(PKT_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BYTES - 1);

    logic [IDX_W-1:0] idx_d, idx_q;

    assign last = (idx_q == LAST_IDX);

    always_comb begin
        idx_d = idx_q;
        if (start) begin
            idx_d = '0;
        end else if (push) begin
            idx_d = last ? '0 : idx_q + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    for (genvar i = 0; i < PKT_BYTES; i++) begin : g_byte
        logic [7:0] byte_d, byte_q;
        always_comb byte_d = (push && idx_q == IDX_W'(i)) ? push_byte : byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) byte_q <= 8'h00;
            else        byte_q <= byte_d;
        end
        assign bytes_flat[8*i +: 8] = byte_q;
    end

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && last && !start) |=> (idx_q == '0))
        else $error("packet index did not wrap"); // R9
endmodule

// File: rtl/pkt_xfer_count.sv
module pkt_xfer_count #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             drained
);
    logic [LEN_W-1:0] rem_d, rem_q;

    assign drained = dec && (rem_q == LEN_W'(1));

    always_comb begin
        rem_d = rem_q;
        if (load)     rem_d = load_val;
        else if (dec) rem_d = rem_q - LEN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (rem_q != '0))
        else $error("byte consumed with nothing left"); // R10
endmodule

// File: rtl/pkt_taskfile_ctrl.sv
module pkt_taskfile_ctrl
    import pkt_taskfile_pkg::*;
#(
    parameter bit DRIVE_ID  = 1'b0,
    parameter int PKT_BYTES = 12,
    parameter int LEN_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_wr,
    input  logic                   host_rd,
    input  logic [3:0]             host_addr,
    input  logic [7:0]             host_wdata,
    output logic [7:0]             host_rdata,
    output logic                   intrq,
    output logic                   pkt_valid,
    output logic [PKT_BYTES*8-1:0] pkt_data,
    input  logic                   be_done,
    input  logic [LEN_W-1:0]       be_len,
    input  logic [3:0]             be_sense,
    output logic                   dma_req,
    input  logic                   dma_ack
);
    tf_state_t  st_d, st_q;
    logic       sel;
    logic       col_start, col_push, col_last;
    logic       cnt_load, cnt_dec, cnt_drained;
    logic       do_reset, consume;
    logic [7:0] sense_err;
    logic [15:0] len_ext;

    pkt_sense_map u_sense (
        .sense_key (be_sense),
        .err_byte  (sense_err)
    );

    pkt_cmd_collector #(.PKT_BYTES(PKT_BYTES)) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (col_start),
        .push       (col_push),
        .push_byte  (host_wdata),
        .last       (col_last),
        .bytes_flat (pkt_data)
    );

    pkt_xfer_count #(.LEN_W(LEN_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (be_len),
        .dec      (cnt_dec),
        .drained  (cnt_drained)
    );

    function automatic tf_state_t with_signature(tf_state_t s, logic keep_dev);
        tf_state_t r = s;
        r.rsn      = RSN_PKT;
        r.lba_lo   = 8'h01;
        r.bc_lo    = SIG_BC_LO;
        r.bc_hi    = SIG_BC_HI;
        r.dev_head = 8'h00;
        if (keep_dev) r.dev_head[DEV_BIT] = s.dev_head[DEV_BIT];
        return r;
    endfunction

    function automatic tf_state_t cmd_finish(tf_state_t s, logic [7:0] eb, logic ef);
        tf_state_t r = s;
        r.error          = eb;
        r.status[ST_BSY]  = 1'b0;
        r.status[ST_DRQ]  = 1'b0;
        r.status[ST_DRDY] = 1'b1;
        r.status[ST_DSC]  = 1'b1;
        r.status[ST_ERR]  = ef;
        r.int_pend       = 1'b1;
        return r;
    endfunction

    function automatic tf_state_t pkt_finish(tf_state_t s, logic [7:0] eb);
        tf_state_t r = cmd_finish(s, eb, |eb);
        r.rsn   = RSN_DONE;
        r.phase = PH_IDLE;
        r.dma   = 1'b0;
        return r;
    endfunction

    assign sel     = (st_q.dev_head[DEV_BIT] == DRIVE_ID);
    assign len_ext = 16'(be_len);

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        col_start = 1'b0;
        col_push  = 1'b0;
        cnt_load  = 1'b0;
        cnt_dec   = 1'b0;
        do_reset  = 1'b0;

        // host register access
        if (host_rd && host_addr == A_CMD && sel) begin
            st_d.int_pend = 1'b0;
        end
        if (host_wr) begin
            unique case (host_addr)
                A_DATA: begin
                    if (sel && st_q.phase == PH_PKT) begin
                        col_push = 1'b1;
                        if (col_last) begin
                            st_d.status[ST_BSY]  = 1'b1;
                            st_d.status[ST_DRDY] = 1'b0;
                            st_d.status[ST_DRQ]  = 1'b0;
                            st_d.bc_lo = 8'h00;
                            st_d.bc_hi = 8'h00;
                            st_d.rsn   = RSN_DONE;
                            st_d.phase = PH_EXEC;
                            st_d.fire  = 1'b1;
                        end
                    end
                end
                A_ERRF: st_d.features = host_wdata;
                A_RSN:  st_d.rsn      = host_wdata;
                A_LBA:  st_d.lba_lo   = host_wdata;
                A_BCL:  st_d.bc_lo    = host_wdata;
                A_BCH:  st_d.bc_hi    = host_wdata;
                A_DEV: begin
                    st_d.dev_head = host_wdata;
                    if (host_wdata[DEV_BIT] == DRIVE_ID && st_q.status == 8'h00) begin
                        st_d.status = 8'h50;
                    end
                end
                A_CMD: begin
                    if ((sel || host_wdata == OP_DIAG) &&
                        !st_q.status[ST_BSY] && !st_q.status[ST_DRQ]) begin
                        unique case (host_wdata)
                            OP_DEV_RESET: begin
                                st_d        = with_signature(st_d, 1'b1);
                                st_d.error  = ER_BASE;
                                st_d.status = 8'h00;
                                st_d.phase  = PH_IDLE;
                            end
                            OP_DIAG: begin
                                st_d = with_signature(st_d, 1'b0);
                                st_d = cmd_finish(st_d, ER_BASE, 1'b0);
                            end
                            OP_PACKET: begin
                                st_d.error           = 8'h00;
                                st_d.status[ST_BSY]  = 1'b0;
                                st_d.status[ST_ERR]  = 1'b0;
                                st_d.status[ST_DRDY] = 1'b1;
                                st_d.status[ST_DSC]  = 1'b1;
                                st_d.status[ST_DRQ]  = 1'b1;
                                st_d.rsn   = RSN_PKT;
                                st_d.phase = PH_PKT;
                                col_start  = 1'b1;
                            end
                            OP_IDENT, OP_READ: begin
                                st_d = with_signature(st_d, 1'b1);
                                st_d = cmd_finish(st_d, ER_ABRT, 1'b1);
                            end
                            default: st_d = cmd_finish(st_d, ER_ABRT, 1'b1);
                        endcase
                    end
                end
                A_CTL: begin
                    st_d.dev_ctl = host_wdata;
                    st_d.dev_ctl[CTL_SRST] = 1'b0;
                    if (host_wdata[CTL_SRST] && !st_q.rst_pend) begin
                        if (!st_q.status[ST_BSY]) begin
                            do_reset = 1'b1;
                        end else begin
                            st_d.rst_pend       = 1'b1;
                            st_d.status[ST_BSY] = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end

        // data phase: one byte per PIO read or DMA acknowledge
        consume = (st_q.phase == PH_DATA) &&
                  ((host_rd && host_addr == A_DATA && sel) || (dma_ack && st_q.dma));
        if (consume) begin
            cnt_dec = 1'b1;
            if (cnt_drained) st_d = pkt_finish(st_d, 8'h00);
        end

        // backend answer
        if (be_done && st_q.phase == PH_EXEC) begin
            if (be_sense != 4'h0 || be_len == '0) begin
                st_d = pkt_finish(st_d, sense_err);
            end else begin
                st_d.bc_lo           = len_ext[7:0];
                st_d.bc_hi           = len_ext[15:8];
                st_d.rsn             = RSN_DATA;
                st_d.status[ST_BSY]  = 1'b0;
                st_d.status[ST_DRQ]  = 1'b1;
                st_d.status[ST_DRDY] = 1'b1;
                st_d.int_pend        = 1'b1;
                st_d.phase           = PH_DATA;
                st_d.dma             = st_d.features[0];
                cnt_load             = 1'b1;
            end
            if (st_q.rst_pend) do_reset = 1'b1;
        end

        if (do_reset) st_d = TF_POWER_ON;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TF_POWER_ON;
        else        st_q <= st_d;
    end

    always_comb begin
        host_rdata = 8'h00;
        if (sel) begin
            unique case (host_addr)
                A_ERRF:       host_rdata = st_q.error;
                A_RSN:        host_rdata = st_q.rsn;
                A_LBA:        host_rdata = st_q.lba_lo;
                A_BCL:        host_rdata = st_q.bc_lo;
                A_BCH:        host_rdata = st_q.bc_hi;
                A_DEV:        host_rdata = st_q.dev_head;
                A_CMD, A_CTL: host_rdata = st_q.status;
                default:      host_rdata = 8'h00;
            endcase
        end
    end

    assign intrq     = st_q.int_pend && !st_q.dev_ctl[CTL_MASK] && sel && !st_q.rst_pend;
    assign pkt_valid = st_q.fire;
    assign dma_req   = (st_q.phase == PH_DATA) && st_q.dma;

    AST_RST_HOLDS_BSY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_pend |-> st_q.status[ST_BSY])
        else $error("waiting reset without BSY"); // R7
    AST_NO_BSY_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.status[ST_BSY] && st_q.status[ST_DRQ]))
        else $error("BSY and DRQ together"); // R10
    AST_PKT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid)
        else $error("packet strobe longer than one cycle"); // R9
    AST_PKT_WHILE_BSY: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> st_q.status[ST_BSY])
        else $error("packet sent while not busy"); // R9
    AST_STATUS_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == A_CMD && sel && !be_done) |=> !st_q.int_pend)
        else $error("status read left interrupt pending"); // R4
    AST_DMA_REQ_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> st_q.status[ST_DRQ])
        else $error("DMA request without DRQ"); // R10
endmodule

// File: tb/pkt_taskfile_ctrl_bench.sv
module pkt_taskfile_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 12;
    localparam int LW = 16;
    localparam int WATCHDOG_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0] host_addr = 4'h0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic intrq, pkt_valid, dma_req;
    logic [NB*8-1:0] pkt_data;
    logic be_done = 1'b0;
    logic [LW-1:0] be_len = '0;
    logic [3:0] be_sense = 4'h0;
    logic dma_ack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_taskfile_ctrl #(.DRIVE_ID(1'b1), .PKT_BYTES(NB), .LEN_W(LW)) u_pkt_taskfile_ctrl (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .intrq(intrq), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .be_done(be_done), .be_len(be_len), .be_sense(be_sense),
        .dma_req(dma_req), .dma_ack(dma_ack)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input string what, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, what, {24'h0, v}, {24'h0, exp});
    endtask

    task automatic backend(input logic [LW-1:0] len, input logic [3:0] sk);
        @(negedge clk);
        be_done = 1'b1; be_len = len; be_sense = sk;
        @(negedge clk);
        be_done = 1'b0;
    endtask

    task automatic send_packet(input logic [7:0] seed);
        wr(4'd7, 8'hA0);
        for (int i = 0; i < NB; i++) wr(4'd0, seed + 8'(i));
    endtask

    task automatic consume(input bit use_dma);
        logic [7:0] v;
        if (use_dma) begin
            @(negedge clk); dma_ack = 1'b1;
            @(negedge clk); dma_ack = 1'b0;
        end else begin
            rd(4'd0, v);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        summary();
    end

    initial begin
        logic [7:0] v;
        logic [NB*8-1:0] exp_pkt;
        int lens[6] = '{1, 2, 7, 12, 255, 259};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2 / R3: power-on state, deselected at first
        chk("R1", "intrq", {31'h0, intrq}, 0);
        chk("R1", "pkt_valid", {31'h0, pkt_valid}, 0);
        chk("R1", "dma_req", {31'h0, dma_req}, 0);
        rd_chk("R2", "status while deselected", 4'd7, 8'h00);
        wr(4'd6, 8'h10);
        rd_chk("R3", "status after select", 4'd7, 8'h50);
        rd_chk("R1", "error", 4'd1, 8'h01);
        rd_chk("R1", "reason", 4'd2, 8'h01);
        rd_chk("R1", "lba low", 4'd3, 8'h01);
        rd_chk("R1", "bc low", 4'd4, 8'h14);
        rd_chk("R1", "bc high", 4'd5, 8'hEB);
        rd_chk("R1", "dev/head", 4'd6, 8'h10);

        // R2: writes land while deselected, reads return zero
        wr(4'd6, 8'h00);
        wr(4'd3, 8'hA5);
        rd_chk("R2", "lba while deselected", 4'd3, 8'h00);
        wr(4'd6, 8'h10);
        rd_chk("R2", "lba after reselect", 4'd3, 8'hA5);

        // R8: non-diag command ignored while deselected
        wr(4'd6, 8'h00);
        wr(4'd7, 8'hEC);
        wr(4'd6, 8'h10);
        rd_chk("R8", "lba kept after ignored command", 4'd3, 8'hA5);
        rd_chk("R8", "status kept after ignored command", 4'd7, 8'h50);
        chk("R8", "no interrupt", {31'h0, intrq}, 0);

        // R8 / R14: diag accepted while deselected
        wr(4'd6, 8'h00);
        wr(4'd7, 8'h90);
        wr(4'd6, 8'h10);
        rd_chk("R8", "diag signature lba", 4'd3, 8'h01);
        rd_chk("R14", "diag error", 4'd1, 8'h01);

        // R5 / R4 / R3: interrupt gating
        wr(4'd7, 8'h25);
        chk("R13", "intrq after abort", {31'h0, intrq}, 1);
        wr(4'd8, 8'h02);
        chk("R5", "intrq masked", {31'h0, intrq}, 0);
        wr(4'd8, 8'h00);
        chk("R5", "intrq unmasked", {31'h0, intrq}, 1);
        wr(4'd6, 8'h00);
        chk("R5", "intrq deselected", {31'h0, intrq}, 0);
        wr(4'd6, 8'h10);
        chk("R5", "intrq reselected", {31'h0, intrq}, 1);
        rd_chk("R3", "nonzero status kept on select", 4'd8, 8'h51);
        chk("R4", "alt read keeps interrupt", {31'h0, intrq}, 1);
        rd_chk("R4", "status read value", 4'd7, 8'h51);
        chk("R4", "status read clears interrupt", {31'h0, intrq}, 0);

        // R6: immediate software reset
        wr(4'd3, 8'h99);
        wr(4'd8, 8'h04);
        rd_chk("R6", "deselected after reset", 4'd7, 8'h00);
        wr(4'd6, 8'h10);
        rd_chk("R6", "status", 4'd7, 8'h50);
        rd_chk("R6", "lba", 4'd3, 8'h01);
        rd_chk("R6", "error", 4'd1, 8'h01);
        chk("R6", "intrq", {31'h0, intrq}, 0);

        // R9 / R8 / R7: packet, busy gating and deferred reset
        wr(4'd1, 8'h00);
        wr(4'd7, 8'hA0);
        rd_chk("R9", "status after PACKET", 4'd7, 8'h58);
        rd_chk("R9", "reason after PACKET", 4'd2, 8'h01);
        wr(4'd7, 8'h25);
        rd_chk("R8", "command ignored under DRQ", 4'd7, 8'h58);
        rd_chk("R8", "error kept under DRQ", 4'd1, 8'h00);
        for (int i = 0; i < NB; i++) begin
            wr(4'd0, 8'h30 + 8'(i));
            exp_pkt[8*i +: 8] = 8'h30 + 8'(i);
            if (i < NB - 1) chk("R9", "no early strobe", {31'h0, pkt_valid}, 0);
        end
        chk("R9", "pkt_valid", {31'h0, pkt_valid}, 1);
        chk("R9", "pkt_data low", pkt_data[31:0], exp_pkt[31:0]);
        chk("R9", "pkt_data high", pkt_data[NB*8-1 -: 32], exp_pkt[NB*8-1 -: 32]);
        @(negedge clk);
        chk("R9", "pkt_valid one cycle", {31'h0, pkt_valid}, 0);
        rd_chk("R9", "status during exec", 4'd7, 8'h90);
        rd_chk("R9", "bc low zero", 4'd4, 8'h00);
        rd_chk("R9", "bc high zero", 4'd5, 8'h00);
        rd_chk("R9", "reason", 4'd2, 8'h03);
        wr(4'd7, 8'hEC);
        rd_chk("R8", "command ignored under BSY", 4'd4, 8'h00);
        wr(4'd8, 8'h04);
        rd_chk("R7", "BSY held", 4'd7, 8'h90);
        chk("R7", "intrq suppressed", {31'h0, intrq}, 0);
        backend(16'd5, 4'h0);
        rd_chk("R7", "reset ran: deselected", 4'd7, 8'h00);
        wr(4'd6, 8'h10);
        rd_chk("R7", "status after reset", 4'd7, 8'h50);
        rd_chk("R7", "bc high after reset", 4'd5, 8'hEB);
        chk("R7", "intrq after reset", {31'h0, intrq}, 0);

        // R11: all sense keys
        for (int k = 0; k < 16; k++) begin
            logic [7:0] e_err;
            e_err = 8'(k << 4) | ((k == 5 || k == 11) ? 8'h04 : 8'h00);
            wr(4'd8, 8'h04);
            wr(4'd6, 8'h10);
            send_packet(8'(k));
            backend((k == 0) ? 16'd0 : 16'd3, 4'(k));
            chk("R11", "intrq", {31'h0, intrq}, 1);
            rd_chk("R11", "error", 4'd1, e_err);
            rd_chk("R11", "reason", 4'd2, 8'h03);
            rd_chk("R11", "bc low", 4'd4, 8'h00);
            rd_chk("R11", "status", 4'd7, (e_err != 0) ? 8'h51 : 8'h50);
        end

        // R10: data phase by PIO and DMA
        for (int m = 0; m < 2; m++) begin
            for (int li = 0; li < 6; li++) begin
                int len;
                len = lens[li];
                wr(4'd8, 8'h04);
                wr(4'd6, 8'h10);
                wr(4'd1, 8'(m));
                send_packet(8'h40);
                backend(16'(len), 4'h0);
                chk("R10", "intrq data ready", {31'h0, intrq}, 1);
                chk("R10", "dma_req", {31'h0, dma_req}, m);
                rd_chk("R10", "bc low", 4'd4, 8'(len & 255));
                rd_chk("R10", "bc high", 4'd5, 8'(len >> 8));
                rd_chk("R10", "reason", 4'd2, 8'h02);
                rd_chk("R10", "status", 4'd7, 8'h58);
                chk("R4", "status read clears", {31'h0, intrq}, 0);
                for (int j = 0; j < len - 1; j++) consume(m != 0);
                rd_chk("R10", "still draining", 4'd8, 8'h58);
                consume(m != 0);
                chk("R10", "intrq complete", {31'h0, intrq}, 1);
                chk("R10", "dma_req dropped", {31'h0, dma_req}, 0);
                rd_chk("R10", "reason done", 4'd2, 8'h03);
                rd_chk("R10", "error", 4'd1, 8'h00);
                rd_chk("R10", "status done", 4'd7, 8'h50);
            end
        end

        // R12 / R13 / R14 / R9: opcode sweep
        for (int op = 0; op < 256; op++) begin
            logic [7:0] e_st, e_er, e_rsn, e_lba, e_bcl, e_bch;
            logic e_irq;
            bit sig, gone;
            string tag;
            wr(4'd8, 8'h04);
            wr(4'd6, 8'h10);
            wr(4'd3, 8'h5A);
            wr(4'd4, 8'h33);
            wr(4'd5, 8'h44);
            wr(4'd2, 8'h77);
            wr(4'd7, 8'(op));
            e_rsn = 8'h77; e_lba = 8'h5A; e_bcl = 8'h33; e_bch = 8'h44;
            e_irq = 1'b1; sig = 1'b0; gone = 1'b0;
            e_st = 8'h51; e_er = 8'h04; tag = "R13";
            case (op)
                8'h08: begin e_st = 8'h00; e_er = 8'h01; sig = 1'b1; e_irq = 1'b0; tag = "R14"; end
                8'h90: begin e_st = 8'h50; e_er = 8'h01; sig = 1'b1; gone = 1'b1; tag = "R14"; end
                8'hA0: begin e_st = 8'h58; e_er = 8'h00; e_rsn = 8'h01; e_irq = 1'b0; tag = "R9"; end
                8'hEC, 8'h20: begin sig = 1'b1; tag = "R12"; end
                default: ;
            endcase
            if (sig) begin e_rsn = 8'h01; e_lba = 8'h01; e_bcl = 8'h14; e_bch = 8'hEB; end
            if (gone) begin
                chk("R2", "intrq deselected by diag", {31'h0, intrq}, 0);
                rd_chk("R2", "status deselected by diag", 4'd7, 8'h00);
                wr(4'd6, 8'h10);
            end
            chk(tag, "intrq", {31'h0, intrq}, {31'h0, e_irq});
            rd_chk(tag, "error", 4'd1, e_er);
            rd_chk(tag, "reason", 4'd2, e_rsn);
            rd_chk(tag, "lba low", 4'd3, e_lba);
            rd_chk(tag, "bc low", 4'd4, e_bcl);
            rd_chk(tag, "bc high", 4'd5, e_bch);
            rd_chk(tag, "dev/head", 4'd6, 8'h10);
            rd_chk(tag, "status", 4'd7, e_st);
        end

        summary();
    end
endmodule